// File: doc/BRIEF.md
# Melody Score Playback Controller

This block sequences the note words of a melody score that a processor selects. Software loads an 8-bit score setting through two 4-bit write ports (upper and lower nibble), then drives a play-enable level. The controller finds where the chosen score starts, steps through its note words, and holds each note for the number of ticks in the note word. While a score plays it shows the tone code of the current note, a busy flag and an LED drive. When playback ends it raises a one-cycle event, which can also be routed to an interrupt request and a hold-release request.

Two trigger modes are selectable. In single mode a rising edge of play-enable starts one pass through the score. In repeat mode the score loops for as long as play-enable stays high. A rising edge of play-enable while the score setting is zero acts as a stop command. The setting is captured when play starts, so software can prepare the next score while the current one runs.

Top module: `score_player`

## Requirements
- R1: After reset the score setting is zero, and busy, led, evt, irq_req and wake_req are all 0 with tone at 0. The upper nibble write sets, from bit 3 to bit 0: LED mode bit 1, LED mode bit 0, repeat-mode bit, score bit 4. The lower nibble write sets score bits 3..0.
- R2: In single mode (repeat bit 0), a rising edge of play_en with a nonzero score makes busy 1 in the following cycle. Busy stays high for exactly the sum of the note durations when tick is high every cycle. Lowering play_en during the pass does not shorten it.
- R3: A rising edge of play_en while the score setting is zero never starts playback. If a score is playing, busy is 0 in the cycle after that edge.
- R4: In repeat mode, play starts whenever play_en is high and the score is nonzero. After the last note the score restarts at its first note with no idle cycle, and busy stays high.
- R5: In repeat mode, lowering play_en lets the current note finish its duration. Playback then stops.
- R6: During playback, nibble writes and further rising edges of play_en with a nonzero score leave the playing score, its mode and its LED mode unchanged.
- R7: A note word is 22 bits: bit 21 is end-of-score, bits 20..10 the duration in ticks, bits 9..0 the tone code. In the built-in table, score s starts at address 4*s and has (s mod 4)+1 notes. Note i lasts i+2 ticks and has tone code 4*s+i. tone shows the current note's code while busy, else 0.
- R8: The duration counter advances only in cycles where tick is high. Without ticks the current note and busy are held.
- R9: In the first cycle after busy falls, evt is 1 for exactly one cycle. irq_req equals evt gated by irq_en, and wake_req equals evt gated by wake_en.
- R10: While busy, LED mode 00 keeps led at 0 and mode 01 keeps it at 1. Mode 10 toggles led at every note change, starting from 0. Mode 11 toggles led after every 256 ticks. When idle, led is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hi_we | input | 1 | Write nib_data into the upper nibble of the score setting |
| lo_we | input | 1 | Write nib_data into the lower nibble of the score setting |
| nib_data | input | 4 | Nibble write data |
| play_en | input | 1 | Play-enable level from software |
| tick | input | 1 | Duration time base, one tick per high cycle |
| irq_en | input | 1 | Route end-of-play event to irq_req |
| wake_en | input | 1 | Route end-of-play event to wake_req |
| busy | output | 1 | Playback active |
| tone | output | 10 | Tone code of the current note, 0 when idle |
| led | output | 1 | LED drive |
| evt | output | 1 | One-cycle pulse after busy falls |
| irq_req | output | 1 | Interrupt request pulse |
| wake_req | output | 1 | Hold-release request pulse |

## Verification
A wrong note address or a wrong duration count shows on tone within one cycle. It shifts every later tone value, so per-cycle comparison of tone against the table catches it at the first cycle that differs. A corrupted captured setting shows up as a wrong pass length or a wrong LED pattern within the same pass. A broken stop or end condition appears as busy staying high, or falling one cycle early or late, and evt moves with it. The slow LED mode is checked at the exact cycle of its first toggle, so an off-by-one in its divider is caught.

// File: rtl/score_pkg.sv
package score_pkg;

    localparam int SCORE_W = 5;
    localparam int NIB_W   = 4;

    typedef enum logic {
        PS_IDLE = 1'b0,
        PS_PLAY = 1'b1
    } play_st_e;

    typedef enum logic [1:0] {
        LED_DARK = 2'b00,
        LED_LIT  = 2'b01,
        LED_NOTE = 2'b10,
        LED_SLOW = 2'b11
    } led_mode_e;

    // Upper nibble = {led_mode, level, score[4]}, lower nibble = score[3:0]
    typedef struct packed {
        led_mode_e            led_mode;
        logic                 level;
        logic [SCORE_W-1:0]   score;
    } cfg_t;

endpackage

// File: rtl/note_store.sv
module note_store
    import score_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int TONE_W = 10,
    parameter int DUR_W  = 11
) (
    input  logic [SCORE_W-1:0]          score,
    input  logic [ADDR_W-1:0]           addr,
    output logic [ADDR_W-1:0]           start_addr,
    output logic [DUR_W+TONE_W:0]       word
);

    localparam int SLOT_W = 2;

    logic [SLOT_W-1:0] slot;
    logic [SLOT_W-1:0] owner_lo;
    logic              last;
    logic [DUR_W-1:0]  dur;

    // Built-in test content: score s owns the four addresses from 4*s,
    // uses (s mod 4)+1 of them, note i lasts i+2 ticks, tone = address.
    always_comb begin
        slot       = addr[SLOT_W-1:0];
        owner_lo   = addr[2*SLOT_W-1:SLOT_W];
        last       = (slot == owner_lo);
        dur        = DUR_W'(slot) + DUR_W'(2);
        start_addr = ADDR_W'({score, {SLOT_W{1'b0}}});
        word       = {last, dur, TONE_W'(addr)};
    end

endmodule

// File: rtl/led_drive.sv
module led_drive
    import score_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      busy,
    input  led_mode_e mode,
    input  logic      step,
    input  logic      tick,
    output logic      led
);

    localparam logic [DIV_W-1:0] DIV_ONE = {{(DIV_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic             tog;
        logic [DIV_W-1:0] div;
    } led_t;

    led_t l_q, l_d;

    always_comb begin
        l_d = l_q;
        if (!busy) begin
            l_d = '0;
        end else begin
            if (tick) begin
                l_d.div = l_q.div + DIV_ONE;
            end
            if (mode == LED_NOTE && step) begin
                l_d.tog = ~l_q.tog;
            end
            if (mode == LED_SLOW && tick && (l_q.div == '1)) begin
                l_d.tog = ~l_q.tog;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            l_q <= '0;
        end else begin
            l_q <= l_d;
        end
    end

    assign led = busy && ((mode == LED_LIT) || (mode[1] && l_q.tog));

    // R10: a toggle during play always follows a note step or a tick
    p_tog_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && (l_q.tog != $past(l_q.tog))) |-> $past(step || tick))
        else $error("led toggled without cause");

    // R10: led dark whenever idle
    p_led_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy) |-> !led)
        else $error("led lit while idle");

endmodule

// File: rtl/busy_event.sv
module busy_event (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic irq_en,
    input  logic wake_en,
    output logic evt,
    output logic irq_req,
    output logic wake_req
);

    logic prev_q, prev_d;

    always_comb begin
        prev_d = busy;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= prev_d;
        end
    end

    assign evt      = prev_q & ~busy;
    assign irq_req  = evt & irq_en;
    assign wake_req = evt & wake_en;

    // R9: the event never lasts two cycles
    p_evt_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> !evt)
        else $error("event pulse longer than one cycle");

endmodule

// File: rtl/score_player.sv
module score_player
    import score_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int TONE_W    = 10,
    parameter int DUR_W     = 11,
    parameter int LED_DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hi_we,
    input  logic              lo_we,
    input  logic [NIB_W-1:0]  nib_data,
    input  logic              play_en,
    input  logic              tick,
    input  logic              irq_en,
    input  logic              wake_en,
    output logic              busy,
    output logic [TONE_W-1:0] tone,
    output logic              led,
    output logic              evt,
    output logic              irq_req,
    output logic              wake_req
);

    localparam int WORD_W = 1 + DUR_W + TONE_W;
    localparam logic [DUR_W-1:0]  DUR_ONE  = {{(DUR_W-1){1'b0}}, 1'b1};
    localparam logic [ADDR_W-1:0] ADDR_ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        play_st_e          st;
        cfg_t              live;
        cfg_t              held;
        logic              play;
        logic [ADDR_W-1:0] addr;
        logic [DUR_W-1:0]  cnt;
    } ctl_t;

    ctl_t c_q, c_d;

    logic [SCORE_W-1:0] lookup_score;
    logic [ADDR_W-1:0]  start_addr;
    logic [WORD_W-1:0]  word;
    logic [TONE_W-1:0]  note_tone;
    logic [DUR_W-1:0]   note_dur;
    logic               note_last;
    logic               rise;
    logic               note_done;
    logic               note_step;

    // Start lookup uses the live score when idle, the captured one when playing
    assign lookup_score = (c_q.st == PS_IDLE) ? c_q.live.score : c_q.held.score;

    note_store #(
        .ADDR_W (ADDR_W),
        .TONE_W (TONE_W),
        .DUR_W  (DUR_W)
    ) u_store (
        .score      (lookup_score),
        .addr       (c_q.addr),
        .start_addr (start_addr),
        .word       (word)
    );

    assign {note_last, note_dur, note_tone} = word;
    assign rise      = play_en & ~c_q.play;
    assign note_done = tick && (({1'b0, c_q.cnt} + {1'b0, DUR_ONE}) >= {1'b0, note_dur});

    always_comb begin
        c_d       = c_q;
        note_step = 1'b0;
        c_d.play  = play_en;

        if (hi_we) begin
            c_d.live.led_mode       = led_mode_e'(nib_data[3:2]);
            c_d.live.level          = nib_data[1];
            c_d.live.score[SCORE_W-1] = nib_data[0];
        end
        if (lo_we) begin
            c_d.live.score[SCORE_W-2:0] = nib_data;
        end

        case (c_q.st)
            PS_IDLE: begin
                if ((c_q.live.score != '0) &&
                    (c_q.live.level ? play_en : rise)) begin
                    c_d.st   = PS_PLAY;
                    c_d.held = c_q.live;
                    c_d.addr = start_addr;
                    c_d.cnt  = '0;
                end
            end
            PS_PLAY: begin
                if (rise && (c_q.live.score == '0)) begin
                    c_d.st = PS_IDLE;
                end else if (note_done) begin
                    c_d.cnt = '0;
                    if (c_q.held.level && !play_en) begin
                        c_d.st = PS_IDLE;
                    end else if (!note_last) begin
                        c_d.addr  = c_q.addr + ADDR_ONE;
                        note_step = 1'b1;
                    end else if (c_q.held.level) begin
                        c_d.addr  = start_addr;
                        note_step = 1'b1;
                    end else begin
                        c_d.st = PS_IDLE;
                    end
                end else if (tick) begin
                    c_d.cnt = c_q.cnt + DUR_ONE;
                end
            end
            default: c_d.st = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign busy = (c_q.st == PS_PLAY);
    assign tone = busy ? note_tone : '0;

    led_drive #(
        .DIV_W (LED_DIV_W)
    ) u_led (
        .clk   (clk),
        .rst_n (rst_n),
        .busy  (busy),
        .mode  (c_q.held.led_mode),
        .step  (note_step),
        .tick  (tick),
        .led   (led)
    );

    busy_event u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy     (busy),
        .irq_en   (irq_en),
        .wake_en  (wake_en),
        .evt      (evt),
        .irq_req  (irq_req),
        .wake_req (wake_req)
    );

    // R6: captured setting does not move while playing
    p_held_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(c_q.held))
        else $error("captured setting changed during play");

    // R3: playback never begins on score zero
    p_start_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (c_q.held.score != '0))
        else $error("started on score zero");

    // R3: stop command ends play in the next cycle
    p_zero_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rise && (c_q.live.score == '0)) |=> !busy)
        else $error("stop command ignored");

    // R8: duration counter stays below the note length
    p_cnt_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ({1'b0, c_q.cnt} < {1'b0, note_dur}))
        else $error("duration counter out of range");

    // R8: no tick, no note change
    p_hold_no_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$past(tick)) |-> $stable(c_q.addr))
        else $error("note advanced without tick");

    // R9: every fall of busy produces the event
    p_fall_evt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> evt)
        else $error("busy fell without event");

endmodule

// File: tb/tb_score_player.sv
module tb_score_player;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hi_we = 1'b0;
    logic       lo_we = 1'b0;
    logic [3:0] nib_data = '0;
    logic       play_en = 1'b0;
    logic       tick = 1'b1;
    logic       irq_en = 1'b0;
    logic       wake_en = 1'b0;
    logic       busy;
    logic [9:0] tone;
    logic       led;
    logic       evt;
    logic       irq_req;
    logic       wake_req;

    int  n_checks = 0;
    int  n_err = 0;
    bit  finished = 1'b0;

    always #5 clk = ~clk;

    score_player dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .hi_we    (hi_we),
        .lo_we    (lo_we),
        .nib_data (nib_data),
        .play_en  (play_en),
        .tick     (tick),
        .irq_en   (irq_en),
        .wake_en  (wake_en),
        .busy     (busy),
        .tone     (tone),
        .led      (led),
        .evt      (evt),
        .irq_req  (irq_req),
        .wake_req (wake_req)
    );

    typedef struct packed {
        logic [4:0] score;
        logic [1:0] led_mode;
        logic       irq;
        logic       wake;
    } vec_t;

    localparam int VEC_N = 7;
    localparam vec_t VEC [VEC_N] = '{
        '{5'd1,  2'b00, 1'b1, 1'b0},
        '{5'd2,  2'b01, 1'b0, 1'b1},
        '{5'd3,  2'b10, 1'b1, 1'b1},
        '{5'd4,  2'b00, 1'b0, 1'b0},
        '{5'd7,  2'b10, 1'b0, 1'b1},
        '{5'd31, 2'b01, 1'b1, 1'b0},
        '{5'd16, 2'b10, 1'b1, 1'b1}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    endtask

    // Called at a negedge; returns two negedges later with the setting live
    task automatic write_cfg(input logic [1:0] lm, input logic lv, input logic [4:0] sc);
        hi_we    = 1'b1;
        nib_data = {lm, lv, sc[4]};
        @(negedge clk);
        hi_we    = 1'b0;
        lo_we    = 1'b1;
        nib_data = sc[3:0];
        @(negedge clk);
        lo_we    = 1'b0;
    endtask

    // Single pass with per-cycle tone and LED comparison (R2, R7, R9, R10)
    task automatic run_oneshot(input vec_t v);
        int nn;
        write_cfg(v.led_mode, 1'b0, v.score);
        irq_en  = v.irq;
        wake_en = v.wake;
        play_en = 1'b1;
        @(negedge clk);
        play_en = 1'b0;                       // R2: early release does not abort
        nn = int'(v.score % 4) + 1;
        for (int i = 0; i < nn; i++) begin
            for (int c = 0; c < i + 2; c++) begin
                chk("R2 busy during pass", int'(busy), 1);
                chk("R7 tone code", int'(tone), 4 * int'(v.score) + i);
                if (v.led_mode == 2'b00) chk("R10 led mode 00", int'(led), 0);
                else if (v.led_mode == 2'b01) chk("R10 led mode 01", int'(led), 1);
                else chk("R10 led mode 10", int'(led), i % 2);
                chk("R9 no event while busy", int'(evt), 0);
                @(negedge clk);
            end
        end
        chk("R2 busy falls after pass", int'(busy), 0);
        chk("R9 event after fall", int'(evt), 1);
        chk("R9 irq gating", int'(irq_req), int'(v.irq));
        chk("R9 wake gating", int'(wake_req), int'(v.wake));
        chk("R7 tone idle", int'(tone), 0);
        chk("R10 led idle", int'(led), 0);
        @(negedge clk);
        chk("R9 event one cycle", int'(evt), 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin : main
        int first_k;
        int edges;
        logic prev_led;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 reset busy", int'(busy), 0);
        chk("R1 reset tone", int'(tone), 0);
        chk("R1 reset led", int'(led), 0);
        chk("R1 reset evt", int'(evt), 0);
        chk("R1 reset irq", int'(irq_req), 0);
        chk("R1 reset wake", int'(wake_req), 0);

        // R3: rising edge with the reset score of zero starts nothing
        play_en = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk("R3 zero score from reset", int'(busy), 0);
        end
        play_en = 1'b0;
        @(negedge clk);

        // Table of single-mode passes (R1 field layout, R2, R7, R9, R10)
        for (int v = 0; v < VEC_N; v++) begin
            run_oneshot(VEC[v]);
        end

        // R8: no ticks hold the first note
        write_cfg(2'b00, 1'b0, 5'd2);
        tick    = 1'b0;
        play_en = 1'b1;
        @(negedge clk);
        play_en = 1'b0;
        repeat (20) begin
            chk("R8 held busy", int'(busy), 1);
            chk("R8 held tone", int'(tone), 8);
            @(negedge clk);
        end
        tick = 1'b1;
        for (int i = 0; i < 3; i++) begin
            for (int c = 0; c < i + 2; c++) begin
                chk("R8 resumed tone", int'(tone), 8 + i);
                @(negedge clk);
            end
        end
        chk("R8 end after resume", int'(busy), 0);
        chk("R9 event after resume", int'(evt), 1);
        @(negedge clk);

        // R6: writes and a new nonzero edge during play are ignored
        write_cfg(2'b00, 1'b0, 5'd3);
        play_en = 1'b1;
        @(negedge clk);
        for (int k = 1; k <= 14; k++) begin
            chk("R6 busy kept", int'(busy), 1);
            chk("R6 led mode kept", int'(led), 0);
            case (k)
                1: begin hi_we = 1'b1; nib_data = 4'b0110; end
                2: begin hi_we = 1'b0; lo_we = 1'b1; nib_data = 4'd4; end
                3: begin lo_we = 1'b0; play_en = 1'b0; end
                4: play_en = 1'b1;
                5: play_en = 1'b0;
                default: ;
            endcase
            @(negedge clk);
        end
        chk("R6 pass length kept", int'(busy), 0);
        write_cfg(2'b00, 1'b0, 5'd0);
        @(negedge clk);

        // R3: stop command during play
        write_cfg(2'b00, 1'b0, 5'd3);
        play_en = 1'b1;
        @(negedge clk);
        chk("R3 playing before stop", int'(busy), 1);
        play_en = 1'b0;
        write_cfg(2'b00, 1'b0, 5'd0);
        chk("R3 still playing", int'(busy), 1);
        play_en = 1'b1;
        @(negedge clk);
        chk("R3 stopped next cycle", int'(busy), 0);
        chk("R9 event on stop", int'(evt), 1);
        play_en = 1'b0;
        @(negedge clk);
        play_en = 1'b1;
        repeat (4) begin
            @(negedge clk);
            chk("R3 idle zero edge", int'(busy), 0);
            chk("R3 idle zero no event", int'(evt), 0);
        end
        play_en = 1'b0;
        @(negedge clk);

        // R4/R5: repeat mode, started by level
        play_en = 1'b1;
        @(negedge clk);
        write_cfg(2'b00, 1'b1, 5'd5);
        chk("R4 not yet started", int'(busy), 0);
        @(negedge clk);
        for (int rep = 0; rep < 3; rep++) begin
            for (int i = 0; i < 2; i++) begin
                for (int c = 0; c < i + 2; c++) begin
                    chk("R4 busy while repeating", int'(busy), 1);
                    chk("R4 repeat tone", int'(tone), 20 + i);
                    @(negedge clk);
                end
            end
        end
        chk("R4 replay restarts", int'(tone), 20);
        play_en = 1'b0;
        @(negedge clk);
        chk("R5 note finishes", int'(tone), 20);
        chk("R5 busy during last note", int'(busy), 1);
        @(negedge clk);
        chk("R5 stops after note", int'(busy), 0);
        chk("R9 event after repeat", int'(evt), 1);
        @(negedge clk);

        // R10: slow LED mode toggles every 256 ticks
        write_cfg(2'b11, 1'b1, 5'd4);
        play_en = 1'b1;
        @(negedge clk);
        first_k  = 0;
        edges    = 0;
        prev_led = led;
        chk("R10 slow led starts dark", int'(led), 0);
        for (int k = 1; k <= 600; k++) begin
            if (led != prev_led) begin
                edges++;
                if (first_k == 0) first_k = k;
            end
            prev_led = led;
            @(negedge clk);
        end
        chk("R10 slow first toggle cycle", first_k, 257);
        chk("R10 slow toggle count", edges, 2);
        play_en = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 slow mode ends", int'(busy), 0);
        chk("R10 led dark idle", int'(led), 0);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule